// File: doc/BRIEF.md
# Successive-Integration Conversion Phase Sequencer

This block is the free-running control sequencer of an integrating converter that resolves its input by successive integration. It first zero-integrates and then integrates the signal for a fixed time. After that it runs three de-integrate phases in a row. Each of the later two works on the residue overshoot that the previous phase left behind, after a rest interval in which that residue is amplified by ten. The sequencer never stops. When one pass ends, it runs the same chain again with the inputs shorted, so that downstream logic can subtract the offset reading from the measurement. A single-cycle end-of-conversion strobe then tells the results counter to latch.

The only analog feedback is a comparator crossing signal. It is asynchronous to the clock and is synchronised internally. The outputs are one-hot switch enables for the analog section, a phase code and a count enable for the up/down results counter, a flag that marks the offset pass, the end-of-conversion strobe and an overrange flag. The overrange flag is raised when a de-integrate phase runs into its time limit. All phase lengths and the time limit are parameters.

Top module: `succint_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it: ph_code is 0, sw_en is 5'b00001, offset_pass, cnt_en, eoc and overrange are 0.
- R2: ph_code steps through 0 (zero-integrate), 1 (signal integrate), 2 (coarse de-integrate), 3 (rest ×10), 4 (fine de-integrate), 5 (rest ×10), 6 (finest de-integrate), and then returns to 0.
- R3: Phases 0, 1 and 3/5 last exactly ZERO_CLKS, INT_CLKS and REST_CLKS cycles respectively.
- R4: cmp_in passes through two flip-flops. A de-integrate phase whose comparator rises after its D-th cycle (D ≥ 1) lasts D+2 cycles, limited to DE_MAX.
- R5: A de-integrate phase with no crossing before its limit lasts exactly DE_MAX cycles and counts as a timeout.
- R6: offset_pass is 0 for the first pass and 1 for the second pass. It toggles only when phase 6 ends.
- R7: sw_en bit assignment: bit0 zero-integrate, bit1 integrate from the signal (measurement pass), bit2 integrate with shorted inputs (offset pass), bit3 any de-integrate phase, bit4 any rest phase. Exactly one bit is high in every cycle.
- R8: cnt_en is high exactly during phases 2, 4 and 6.
- R9: eoc is high for one cycle only: the first cycle of phase 0 after the offset pass ends. There is one pulse per conversion.
- R10: overrange is updated only together with eoc. It is 1 when any of the six de-integrate phases of that conversion timed out, and it holds its value until the next eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator crossing |
| sw_en | output | 5 | One-hot analog switch enables |
| ph_code | output | 3 | Current phase code |
| cnt_en | output | 1 | Results-counter count enable |
| offset_pass | output | 1 | High during the shorted-input pass |
| eoc | output | 1 | End-of-conversion latch strobe |
| overrange | output | 1 | A de-integrate timed out in the last conversion |

## Verification
The assertions accept any value on cmp_in. They do assume that a crossing seen late in one de-integrate phase has left the two synchroniser stages before the next de-integrate phase starts, so REST_CLKS must be at least 3. The stimulus raises the comparator only inside a de-integrate phase, at a chosen cycle. It drops the comparator in the first cycle of the phase that follows. The stimulus sweeps that cycle across the whole timeout window and also includes phases that receive no crossing at all.

// File: rtl/succint_sequencer.sv
module succint_sequencer #(
  parameter int INT_CLKS  = 10000,
  parameter int ZERO_CLKS = 2000,
  parameter int REST_CLKS = 1000,
  parameter int DE_MAX    = 24000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_in,
  output logic [4:0] sw_en,
  output logic [2:0] ph_code,
  output logic       cnt_en,
  output logic       offset_pass,
  output logic       eoc,
  output logic       overrange
);

  localparam int M1 = (INT_CLKS > ZERO_CLKS) ? INT_CLKS : ZERO_CLKS;
  localparam int M2 = (REST_CLKS > DE_MAX) ? REST_CLKS : DE_MAX;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXL + 1);

  localparam logic [2:0] P_ZERO  = 3'd0;
  localparam logic [2:0] P_INTEG = 3'd1;
  localparam logic [2:0] P_DE1   = 3'd2;
  localparam logic [2:0] P_REST1 = 3'd3;
  localparam logic [2:0] P_DE2   = 3'd4;
  localparam logic [2:0] P_REST2 = 3'd5;
  localparam logic [2:0] P_DE3   = 3'd6;

  logic [2:0]    ph_q, ph_d;
  logic [CW-1:0] cnt_q, lim;
  logic          off_q, s1, s2, ovr_acc, ovr_q, eoc_q;

  wire is_de   = (ph_q == P_DE1) | (ph_q == P_DE2) | (ph_q == P_DE3);
  wire is_rest = (ph_q == P_REST1) | (ph_q == P_REST2);
  wire at_lim  = (cnt_q == lim);
  wire timeout = is_de & at_lim & ~s2;
  wire done    = is_de ? (s2 | at_lim) : at_lim;
  wire last    = done & (ph_q == P_DE3) & off_q;

  always_comb begin
    case (ph_q)
      P_ZERO:  lim = CW'(ZERO_CLKS - 1);
      P_INTEG: lim = CW'(INT_CLKS - 1);
      P_REST1,
      P_REST2: lim = CW'(REST_CLKS - 1);
      default: lim = CW'(DE_MAX - 1);
    endcase
    ph_d = (ph_q == P_DE3) ? P_ZERO : ph_q + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= P_ZERO;
      cnt_q   <= '0;
      off_q   <= 1'b0;
      s1      <= 1'b0;
      s2      <= 1'b0;
      ovr_acc <= 1'b0;
      ovr_q   <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      s1    <= cmp_in;
      s2    <= s1;
      eoc_q <= last;
      if (done) begin
        ph_q  <= ph_d;
        cnt_q <= '0;
        if (ph_q == P_DE3) off_q <= ~off_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (last) begin
        ovr_q   <= ovr_acc | timeout;
        ovr_acc <= 1'b0;
      end else if (timeout) begin
        ovr_acc <= 1'b1;
      end
    end
  end

  assign sw_en = {is_rest, is_de, (ph_q == P_INTEG) & off_q,
                  (ph_q == P_INTEG) & ~off_q, ph_q == P_ZERO};
  assign ph_code     = ph_q;
  assign cnt_en      = is_de;
  assign offset_pass = off_q;
  assign eoc         = eoc_q;
  assign overrange   = ovr_q;

  a_r7_onehot_switch: assert property (@(posedge clk) disable iff (rst)
    $onehot(sw_en));

  a_r2_after_de1: assert property (@(posedge clk) disable iff (rst)
    (ph_code == P_DE1) |=> (ph_code == P_DE1 || ph_code == P_REST1));

  a_r2_after_de3: assert property (@(posedge clk) disable iff (rst)
    (ph_code == P_DE3) |=> (ph_code == P_DE3 || ph_code == P_ZERO));

  a_r2_after_rest2: assert property (@(posedge clk) disable iff (rst)
    (ph_code == P_REST2) |=> (ph_code == P_REST2 || ph_code == P_DE3));

  a_r6_pass_stable: assert property (@(posedge clk) disable iff (rst)
    (ph_code != P_DE3) |=> $stable(offset_pass));

  a_r5_de_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_en |-> (cnt_q < CW'(DE_MAX)));

  a_r9_eoc_place: assert property (@(posedge clk) disable iff (rst)
    eoc |-> (ph_code == P_ZERO && !offset_pass && cnt_q == '0));

  a_r9_eoc_pulse: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);

  a_r10_ovr_hold: assert property (@(posedge clk) disable iff (rst)
    !eoc |-> $stable(overrange));

endmodule

// File: tb/sim_succint_sequencer.sv
module sim_succint_sequencer;
  localparam int ZC = 8, IC = 20, RC = 5, DM = 12;

  logic clk = 1'b0, rst = 1'b1, cmp_in = 1'b0;
  logic [4:0] sw_en;
  logic [2:0] ph_code;
  logic cnt_en, offset_pass, eoc, overrange;
  int checks = 0, failures = 0, eoc_seen = 0, convs = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  succint_sequencer #(.INT_CLKS(IC), .ZERO_CLKS(ZC), .REST_CLKS(RC), .DE_MAX(DM)) u0 (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .sw_en(sw_en), .ph_code(ph_code),
    .cnt_en(cnt_en), .offset_pass(offset_pass), .eoc(eoc), .overrange(overrange));

  always @(negedge clk) if (!rst && eoc) eoc_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_sw(input int code, input bit off);
    case (code)
      0: return 5'b00001;
      1: return off ? 5'b00100 : 5'b00010;
      3, 5: return 5'b10000;
      default: return 5'b01000;
    endcase
  endfunction

  function automatic bit tmo(input int d);
    return (d == 0) || (d + 2 > DM);
  endfunction

  function automatic int de_len(input int d);
    return tmo(d) ? DM : d + 2;
  endfunction

  task automatic phase(input int code, input bit off, input int len, input int delay);
    int n = 0;
    bit sw_bad = 0, en_bad = 0;
    chk(ph_code == 3'(code), "R2 phase order", ph_code, code);
    chk(offset_pass == off, "R6 pass flag", offset_pass, off);
    while (ph_code == 3'(code) && n < 1000) begin
      n++;
      if (sw_en != exp_sw(code, off)) sw_bad = 1;
      if (cnt_en != (code == 2 || code == 4 || code == 6)) en_bad = 1;
      if (delay != 0 && n == delay) cmp_in = 1'b1;
      @(negedge clk);
    end
    cmp_in = 1'b0;
    chk(!sw_bad, "R7 switch enables", sw_en, exp_sw(code, off));
    chk(!en_bad, "R8 count enable", cnt_en, 0);
    if (code == 2 || code == 4 || code == 6)
      chk(n == len, (delay == 0 || tmo(delay)) ? "R5 timeout length" : "R4 de-integrate length", n, len);
    else
      chk(n == len, "R3 fixed length", n, len);
  endtask

  task automatic run_conv(input int d0, input int d1, input int d2,
                          input int d3, input int d4, input int d5);
    int d[6];
    bit ov;
    d = '{d0, d1, d2, d3, d4, d5};
    ov = 0;
    for (int p = 0; p < 2; p++) begin
      phase(0, p[0], ZC, 0);
      phase(1, p[0], IC, 0);
      phase(2, p[0], de_len(d[p*3]), d[p*3]);
      phase(3, p[0], RC, 0);
      phase(4, p[0], de_len(d[p*3+1]), d[p*3+1]);
      phase(5, p[0], RC, 0);
      phase(6, p[0], de_len(d[p*3+2]), d[p*3+2]);
    end
    for (int k = 0; k < 6; k++) if (tmo(d[k])) ov = 1;
    convs++;
    chk(eoc == 1'b1, "R9 eoc at new zero phase", eoc, 1);
    chk(overrange == ov, "R10 overrange", overrange, ov);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ph_code == 0 && sw_en == 5'b00001, "R1 reset phase", sw_en, 1);
    chk(!offset_pass && !cnt_en && !eoc && !overrange, "R1 reset flags",
        {offset_pass, cnt_en, eoc, overrange}, 0);
    rst = 1'b0;
    chk(ph_code == 0 && !eoc && !overrange, "R1 first cycle", ph_code, 0);
    for (int dd = 1; dd < DM; dd++)
      run_conv(dd, DM - dd, (dd % 4) + 1, dd, 2, DM - 1);
    run_conv(0, 3, 3, 3, 3, 3);
    run_conv(3, 3, 3, 3, 3, 3);
    run_conv(1, 1, 1, 1, 1, 0);
    run_conv(4, 5, 6, 7, 8, 9);
    @(negedge clk);
    chk(eoc == 1'b0, "R9 single-cycle eoc", eoc, 0);
    chk(eoc_seen == convs, "R9 one pulse per conversion", eoc_seen, convs);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule